// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit sits beside the five-stage integer pipeline and decides where each ALU operand comes from, when the front end must freeze, and when the instruction waiting in decode must be discarded. For the instruction in execute, it compares both source register numbers with the destination of the instruction one stage ahead (memory) and two stages ahead (write-back). It then drives one 2-bit operand-source select per ALU input. The operand multiplexers, the register file and the ALU are outside the block.

The unit also owns the fetch-to-decode instruction register. When a load in the execute-entry register writes a register that the decoding instruction reads, the unit stalls. The program counter and the decode register hold, and the control word passed into the execute-entry register is forced to zero, so one bubble enters the pipeline and the held instruction is effectively fetched twice. A taken branch raises a flush. The decode register is cleared to zero, which is a nop, and the control word is zeroed in the same way. A flush overrides a stall, because the instruction that caused the stall is on the wrong path.

Top module: `hzu_top`

## Requirements
- R1: Each of the two operand selects (`fwd_a_sel` for the first source, `fwd_b_sel` for the second) is decided independently and uses the code 2'b00 = register-file value, 2'b10 = memory-stage result, 2'b01 = write-back data; 2'b11 never appears.
- R2: A select is 2'b10 when its source register equals `exmem_rd`, `exmem_regwrite` is 1 and `exmem_rd` is not 0.
- R3: A select is 2'b01 when its source equals `memwb_rd`, `memwb_regwrite` is 1, `memwb_rd` is not 0, and the R2 condition does not hold for that source.
- R4: When both the memory and write-back stages qualify for the same source, the select is 2'b10.
- R5: A destination of register 0, or a stage whose write enable is 0, never causes forwarding; the select is then 2'b00.
- R6: `stall` is 1 and `pc_write` is 0 when `idex_memread` is 1 and `idex_rt` equals field [25:21] or field [20:16] of `ifid_instr`, and `branch_taken` is 0.
- R7: While `stall` is 1, `ifid_instr` keeps its value across the clock edge and `ctrl_out` is all zeros.
- R8: When `branch_taken` is 1, `if_flush` is 1, `stall` is 0, `pc_write` is 1, `ctrl_out` is zero, and `ifid_instr` is zero after the next edge.
- R9: With neither stall nor flush, `pc_write` is 1, `ctrl_out` equals `ctrl_in`, and `ifid_instr` takes `fetch_instr` at each edge.
- R10: Synchronous active-low reset clears `ifid_instr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_rs | input | RAW | First source register of the instruction in execute |
| ex_rt | input | RAW | Second source register of the instruction in execute |
| exmem_regwrite | input | 1 | Memory-stage instruction writes a register |
| exmem_rd | input | RAW | Memory-stage destination register |
| memwb_regwrite | input | 1 | Write-back-stage instruction writes a register |
| memwb_rd | input | RAW | Write-back-stage destination register |
| idex_memread | input | 1 | Instruction entering execute is a load |
| idex_rt | input | RAW | Destination register of that load |
| fetch_instr | input | INSTR_W | Instruction word from fetch |
| branch_taken | input | 1 | A branch resolved as taken this cycle |
| ctrl_in | input | CTRL_W | Control word from the decoder |
| fwd_a_sel | output | 2 | Source select for ALU input A |
| fwd_b_sel | output | 2 | Source select for ALU input B |
| stall | output | 1 | Load-use interlock active |
| pc_write | output | 1 | Program counter may update |
| if_flush | output | 1 | Decode register is being cleared |
| ifid_instr | output | INSTR_W | Instruction held for decode |
| ctrl_out | output | CTRL_W | Control word into the execute-entry register |

## Verification
The hardest situation to reach is a load-use hazard that coincides with a taken branch, or a hazard that persists so the decode register must hold over several consecutive edges. The bench draws register numbers from only four values, so that destination and source fields collide often. It also places small register numbers into the [25:21] and [20:16] fields of each fetched word, which makes stalls frequent, and it runs directed sequences that stall twice in a row and then flush over a pending hazard.

// File: rtl/hzu_pkg.sv
// Shared types for the forwarding and interlock unit.
// Assumes a two-bit operand-source select driven to the ALU input muxes.
package hzu_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/hzu_fwd_pick.sv
// Chooses the source of one ALU operand from the register numbers of the
// instruction in execute and of the two producer stages ahead of it.
// Assumes destination 0 is a hard-wired zero register and is never forwarded.
module hzu_fwd_pick
    import hzu_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] src,
    input  logic           mem_we,
    input  logic [RAW-1:0] mem_rd,
    input  logic           wb_we,
    input  logic [RAW-1:0] wb_rd,
    output opnd_src_e      sel
);
    localparam logic [RAW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Decide which producer, if any, holds a newer value of src.
    always_comb begin
        mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_REGFILE;
    end

    // R1: the unused code never leaves this module.
    always_comb begin
        assert_sel_legal_R1: assert (sel != opnd_src_e'(2'b11))
            else $error("illegal operand select");
    end
endmodule

// File: rtl/hzu_loaduse.sv
// Flags a load whose destination is read by the instruction in decode.
// Assumes both decode source fields are compared, used or not.
module hzu_loaduse #(
    parameter int RAW = 5
) (
    input  logic           ld_valid,
    input  logic [RAW-1:0] ld_rt,
    input  logic [RAW-1:0] id_rs,
    input  logic [RAW-1:0] id_rt,
    output logic           hazard
);
    // Compare the load destination with both decode sources.
    always_comb begin
        hazard = ld_valid && ((ld_rt == id_rs) || (ld_rt == id_rt));
    end
endmodule

// File: rtl/hzu_ifid_reg.sv
// Fetch-to-decode instruction register with hold and clear.
// Assumes clear (flush) takes precedence over hold; an all-zero word is a nop.
module hzu_ifid_reg #(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               clear,
    input  logic [INSTR_W-1:0] d,
    output logic [INSTR_W-1:0] q
);
    // Load, hold or clear the decode instruction each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clear) q <= '0;
        else if (!hold) q <= d;
    end

    // R8: a flush leaves a nop in decode.
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q == '0));

    // R7: a hold keeps the word across the edge.
    assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> (q == $past(q)));
endmodule

// File: rtl/hzu_top.sv
// Forwarding selection, load-use interlock and taken-branch flush for a
// five-stage pipeline. Owns the decode instruction register; the operand
// muxes, register file and ALU are external. Assumes the source fields of a
// decode word sit at RS_LSB and RT_LSB, each RAW bits wide.
module hzu_top
    import hzu_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int RAW     = 5,
    parameter int CTRL_W  = 9,
    parameter int RS_LSB  = 21,
    parameter int RT_LSB  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RAW-1:0]     ex_rs,
    input  logic [RAW-1:0]     ex_rt,
    input  logic               exmem_regwrite,
    input  logic [RAW-1:0]     exmem_rd,
    input  logic               memwb_regwrite,
    input  logic [RAW-1:0]     memwb_rd,
    input  logic               idex_memread,
    input  logic [RAW-1:0]     idex_rt,
    input  logic [INSTR_W-1:0] fetch_instr,
    input  logic               branch_taken,
    input  logic [CTRL_W-1:0]  ctrl_in,
    output logic [1:0]         fwd_a_sel,
    output logic [1:0]         fwd_b_sel,
    output logic               stall,
    output logic               pc_write,
    output logic               if_flush,
    output logic [INSTR_W-1:0] ifid_instr,
    output logic [CTRL_W-1:0]  ctrl_out
);
    localparam int NUM_OPND = 2;

    logic [RAW-1:0] opnd_src [NUM_OPND];
    opnd_src_e      opnd_sel [NUM_OPND];
    logic           lu_hazard;
    logic           bubble;
    logic [RAW-1:0] id_rs;
    logic [RAW-1:0] id_rt;

    // Gather the execute-stage source numbers into an indexed set.
    always_comb begin
        opnd_src[0] = ex_rs;
        opnd_src[1] = ex_rt;
    end

    // One selector per ALU operand.
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hzu_fwd_pick #(.RAW(RAW)) u_pick (
            .src    (opnd_src[g]),
            .mem_we (exmem_regwrite),
            .mem_rd (exmem_rd),
            .wb_we  (memwb_regwrite),
            .wb_rd  (memwb_rd),
            .sel    (opnd_sel[g])
        );
    end

    // Drive the select ports from the selector results.
    always_comb begin
        fwd_a_sel = opnd_sel[0];
        fwd_b_sel = opnd_sel[1];
    end

    // Extract the decode-stage source fields.
    always_comb begin
        id_rs = ifid_instr[RS_LSB +: RAW];
        id_rt = ifid_instr[RT_LSB +: RAW];
    end

    hzu_loaduse #(.RAW(RAW)) u_loaduse (
        .ld_valid (idex_memread),
        .ld_rt    (idex_rt),
        .id_rs    (id_rs),
        .id_rt    (id_rt),
        .hazard   (lu_hazard)
    );

    // Resolve stall against flush and form the front-end controls.
    always_comb begin
        if_flush = branch_taken;
        stall    = lu_hazard && !branch_taken;
        pc_write = !stall;
        bubble   = stall || if_flush;
        ctrl_out = bubble ? '0 : ctrl_in;
    end

    hzu_ifid_reg #(.INSTR_W(INSTR_W)) u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (stall),
        .clear (if_flush),
        .d     (fetch_instr),
        .q     (ifid_instr)
    );

    // R4: a newer memory-stage producer wins over write-back for operand A.
    assert_mem_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_regwrite && exmem_rd != '0 && exmem_rd == ex_rs &&
         memwb_regwrite && memwb_rd == ex_rs) |-> (fwd_a_sel == 2'b10));

    // R5: register 0 is never a forwarding destination.
    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_rd == '0 && memwb_rd == '0) |-> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

    // R6: a load feeding the decode first source must interlock.
    assert_loaduse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_memread && idex_rt == ifid_instr[RS_LSB +: RAW] && !branch_taken)
        |-> (stall && !pc_write));

    // R8: a taken branch always lets the program counter move.
    assert_flush_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (pc_write && ctrl_out == '0));
endmodule

// File: tb/hzu_top_bench.sv
module hzu_top_bench;
    localparam int INSTR_W = 32;
    localparam int RAW     = 5;
    localparam int CTRL_W  = 9;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [RAW-1:0]     ex_rs = '0, ex_rt = '0, exmem_rd = '0, memwb_rd = '0, idex_rt = '0;
    logic               exmem_regwrite = 1'b0, memwb_regwrite = 1'b0;
    logic               idex_memread = 1'b0, branch_taken = 1'b0;
    logic [INSTR_W-1:0] fetch_instr = '0;
    logic [CTRL_W-1:0]  ctrl_in = '0;
    logic [1:0]         fwd_a_sel, fwd_b_sel;
    logic               stall, pc_write, if_flush;
    logic [INSTR_W-1:0] ifid_instr;
    logic [CTRL_W-1:0]  ctrl_out;

    int checks = 0;
    int errors = 0;
    logic [INSTR_W-1:0] exp_ifid = '0;

    always #4 clk = ~clk;

    hzu_top u_hzu_top (
        .clk(clk), .rst_n(rst_n), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .exmem_regwrite(exmem_regwrite), .exmem_rd(exmem_rd),
        .memwb_regwrite(memwb_regwrite), .memwb_rd(memwb_rd),
        .idex_memread(idex_memread), .idex_rt(idex_rt),
        .fetch_instr(fetch_instr), .branch_taken(branch_taken), .ctrl_in(ctrl_in),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall(stall),
        .pc_write(pc_write), .if_flush(if_flush), .ifid_instr(ifid_instr),
        .ctrl_out(ctrl_out)
    );

    function automatic logic [1:0] exp_sel(input logic [RAW-1:0] s);
        if (exmem_regwrite && exmem_rd != 0 && exmem_rd == s) return 2'b10;
        if (memwb_regwrite && memwb_rd != 0 && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return idex_memread && !branch_taken &&
               (idex_rt == exp_ifid[25:21] || idex_rt == exp_ifid[20:16]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Inputs already set; check combinational outputs, step one edge, check register.
    task automatic step();
        logic st;
        @(negedge clk);
        #1;
        st = exp_stall();
        chk("R1/R2/R3/R4/R5 fwd_a", fwd_a_sel, exp_sel(ex_rs));
        chk("R1/R2/R3/R4/R5 fwd_b", fwd_b_sel, exp_sel(ex_rt));
        chk("R6 stall", stall, st);
        chk("R6/R8/R9 pc_write", pc_write, !st);
        chk("R8 if_flush", if_flush, branch_taken);
        chk("R7/R8/R9 ctrl_out", ctrl_out, (st || branch_taken) ? '0 : ctrl_in);
        if (branch_taken) exp_ifid = '0;
        else if (!st)     exp_ifid = fetch_instr;
        @(posedge clk);
        #1;
        chk("R7/R8/R9 ifid_instr", ifid_instr, exp_ifid);
    endtask

    task automatic set_fwd(input logic [RAW-1:0] a, input logic [RAW-1:0] b,
                           input logic mw, input logic [RAW-1:0] mrd,
                           input logic ww, input logic [RAW-1:0] wrd);
        ex_rs = a; ex_rt = b; exmem_regwrite = mw; exmem_rd = mrd;
        memwb_regwrite = ww; memwb_rd = wrd;
    endtask

    function automatic logic [INSTR_W-1:0] mk_instr(input logic [RAW-1:0] rs, input logic [RAW-1:0] rt);
        logic [INSTR_W-1:0] w;
        w = $urandom;
        w[25:21] = rs;
        w[20:16] = rt;
        return w;
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset ifid", ifid_instr, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: both stages produce r3; memory stage wins. R2 on b via r3 too.
        set_fwd(5'd3, 5'd3, 1'b1, 5'd3, 1'b1, 5'd3);
        ctrl_in = 9'h1A5; fetch_instr = mk_instr(5'd7, 5'd8);
        step();
        // R3: only write-back matches operand b.
        set_fwd(5'd1, 5'd6, 1'b1, 5'd2, 1'b1, 5'd6);
        step();
        // R5: destination 0 and disabled writes never forward.
        set_fwd(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        step();
        set_fwd(5'd4, 5'd5, 1'b0, 5'd4, 1'b0, 5'd5);
        step();
        // R6/R7: load into r7 read by decode (rs field) -> two stalls in a row.
        idex_memread = 1'b1; idex_rt = 5'd7; fetch_instr = mk_instr(5'd9, 5'd9);
        step();
        step();
        // R6: match on the rt field.
        idex_rt = 5'd8;
        step();
        // R8: flush over a pending hazard.
        branch_taken = 1'b1;
        step();
        branch_taken = 1'b0; idex_memread = 1'b0;
        fetch_instr = mk_instr(5'd2, 5'd3);
        // R9: plain pass-through.
        step();

        for (int i = 0; i < 3000; i++) begin
            set_fwd(RAW'($urandom % 4), RAW'($urandom % 4), 1'($urandom), RAW'($urandom % 4),
                    1'($urandom), RAW'($urandom % 4));
            idex_memread = ($urandom % 3) == 0;
            idex_rt      = RAW'($urandom % 4);
            branch_taken = ($urandom % 7) == 0;
            ctrl_in      = CTRL_W'($urandom);
            fetch_instr  = mk_instr(RAW'($urandom % 4), RAW'($urandom % 4));
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule